// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a 14-bit sample code into the 51 on/off controls of a current-steering converter array that is split into three segments of different weight. A new code is taken into an input register whenever the valid strobe is high. The registered code is divided into three fields. The upper five bits select how many of 31 equal coarse cells are on. The next four bits select how many of 15 equal middle cells are on. The lowest five bits drive five binary-weighted fine cells directly.

The decoded control word then passes through a second register, so every switch in the array changes on the same clock edge. The analog cells, their weighting and the summing node lie outside this block. The weights that this block assumes for its outputs are 512 units for a coarse cell, 32 units for a middle cell and 2^i units for fine bit i. With those weights the array's total always equals the code that was loaded.

Top module: `segdac_switch_decoder`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears both registers, so all 51 bits of sw_bus are 0 after that edge. This output state stands for code 0.
- R2: A code presented with valid_in high at rising edge n appears on sw_bus after edge n+1, which is two clock edges, and not earlier.
- R3: When valid_in is low at an edge, the code at that edge is ignored. sw_bus then holds the value it had one cycle earlier.
- R4: sw_bus[50:20] are the coarse lines, with line i at bit 20+i. For a coarse field (code bits 13:9) of value k, lines 0 to k-1 are on and all other coarse lines are off.
- R5: sw_bus[19:5] are the middle lines, with line j at bit 5+j. For a middle field (code bits 8:5) of value m, lines 0 to m-1 are on and all other middle lines are off.
- R6: sw_bus[4:0] equal code bits 4:0 of the loaded code, bit for bit.
- R7: For every one of the 16384 codes, 512·(coarse lines on) + 32·(middle lines on) + sw_bus[4:0] equals the loaded code.
- R8: Between two consecutive output states, if the number of lines on in a thermometer segment increases, no line of that segment goes from on to off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Loads code_in into the input register when high |
| code_in | input | 14 | Unsigned sample code |
| sw_bus | output | 51 | Registered switch controls: [50:20] coarse, [19:5] middle, [4:0] fine |

## Verification
The hardest situation to reach is a transition that crosses both thermometer boundaries at once, such as 511 to 512 or 16383 to 0. In the first case the middle segment collapses while the coarse segment grows by one cell. Such cases appear only if successive codes are chosen to straddle those boundaries. An ascending sweep through all 16384 codes, streamed one per cycle, produces every carry from the fine field into the middle field and from the middle field into the coarse field. Directed full-scale and boundary codes and random bursts with gaps in the valid strobe add the downward jumps and the hold behaviour.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    // Default field widths of the three segments.
    localparam int unsigned DEF_MSB_W = 5;
    localparam int unsigned DEF_MID_W = 4;
    localparam int unsigned DEF_LSB_W = 5;

    // Number of unary lines needed for a field of the given width.
    function automatic int unsigned therm_lines(input int unsigned bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/segdac_in_stage.sv
module segdac_in_stage #(
    parameter int unsigned CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.code = code_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;

endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
    parameter int unsigned BITS  = 5,
    parameter int unsigned LINES = (1 << BITS) - 1
) (
    input  logic [BITS-1:0]  val_i,
    output logic [LINES-1:0] lines_o
);

    // Line g is on whenever the field value exceeds g, so a value k
    // lights exactly the k lowest lines and growth never clears one.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lines_o[g] = (val_i > BITS'(g));
    end

endmodule

// File: rtl/segdac_decode.sv
module segdac_decode
    import seg_dac_pkg::*;
#(
    parameter int unsigned MSB_W = DEF_MSB_W,
    parameter int unsigned MID_W = DEF_MID_W,
    parameter int unsigned LSB_W = DEF_LSB_W,
    localparam int unsigned CODE_W    = MSB_W + MID_W + LSB_W,
    localparam int unsigned MSB_LINES = therm_lines(MSB_W),
    localparam int unsigned MID_LINES = therm_lines(MID_W),
    localparam int unsigned BUS_W     = MSB_LINES + MID_LINES + LSB_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [BUS_W-1:0]  bus_o
);

    localparam int unsigned LSB_BASE = 0;
    localparam int unsigned MID_BASE = LSB_W;
    localparam int unsigned MSB_BASE = LSB_W + MID_LINES;

    logic [MSB_W-1:0]     msb_field;
    logic [MID_W-1:0]     mid_field;
    logic [LSB_W-1:0]     lsb_field;
    logic [MSB_LINES-1:0] msb_lines;
    logic [MID_LINES-1:0] mid_lines;

    assign msb_field = code_i[CODE_W-1 -: MSB_W];
    assign mid_field = code_i[LSB_W +: MID_W];
    assign lsb_field = code_i[LSB_W-1:0];

    segdac_therm #(
        .BITS  (MSB_W),
        .LINES (MSB_LINES)
    ) u_msb_therm (
        .val_i   (msb_field),
        .lines_o (msb_lines)
    );

    segdac_therm #(
        .BITS  (MID_W),
        .LINES (MID_LINES)
    ) u_mid_therm (
        .val_i   (mid_field),
        .lines_o (mid_lines)
    );

    assign bus_o[MSB_BASE +: MSB_LINES] = msb_lines;
    assign bus_o[MID_BASE +: MID_LINES] = mid_lines;

    for (genvar b = 0; b < LSB_W; b++) begin : g_fine
        assign bus_o[LSB_BASE + b] = lsb_field[b];
    end

endmodule

// File: rtl/segdac_out_stage.sv
module segdac_out_stage #(
    parameter int unsigned BUS_W = 51
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] bus_o
);

    typedef struct packed {
        logic [BUS_W-1:0] bus;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d.bus = bus_i;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_o = st_q.bus;

endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder
    import seg_dac_pkg::*;
#(
    parameter int unsigned MSB_W = DEF_MSB_W,
    parameter int unsigned MID_W = DEF_MID_W,
    parameter int unsigned LSB_W = DEF_LSB_W,
    localparam int unsigned CODE_W    = MSB_W + MID_W + LSB_W,
    localparam int unsigned MSB_LINES = therm_lines(MSB_W),
    localparam int unsigned MID_LINES = therm_lines(MID_W),
    localparam int unsigned BUS_W     = MSB_LINES + MID_LINES + LSB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [BUS_W-1:0]  sw_bus
);

    logic [CODE_W-1:0] code_q;
    logic [BUS_W-1:0]  dec_bus;

    segdac_in_stage #(
        .CODE_W (CODE_W)
    ) u_in (
        .clk    (clk),
        .rst    (rst),
        .load   (valid_in),
        .code_i (code_in),
        .code_o (code_q)
    );

    segdac_decode #(
        .MSB_W (MSB_W),
        .MID_W (MID_W),
        .LSB_W (LSB_W)
    ) u_dec (
        .code_i (code_q),
        .bus_o  (dec_bus)
    );

    segdac_out_stage #(
        .BUS_W (BUS_W)
    ) u_out (
        .clk   (clk),
        .rst   (rst),
        .bus_i (dec_bus),
        .bus_o (sw_bus)
    );

endmodule

// File: rtl/segdac_switch_checker.sv
module segdac_switch_checker #(
    parameter int unsigned MSB_W = 5,
    parameter int unsigned MID_W = 4,
    parameter int unsigned LSB_W = 5,
    localparam int unsigned CODE_W    = MSB_W + MID_W + LSB_W,
    localparam int unsigned MSB_LINES = (1 << MSB_W) - 1,
    localparam int unsigned MID_LINES = (1 << MID_W) - 1,
    localparam int unsigned BUS_W     = MSB_LINES + MID_LINES + LSB_W,
    localparam int unsigned MID_BASE  = LSB_W,
    localparam int unsigned MSB_BASE  = LSB_W + MID_LINES,
    localparam int MID_WT = 1 << LSB_W,
    localparam int MSB_WT = 1 << (LSB_W + MID_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [CODE_W-1:0] code_in,
    input logic [BUS_W-1:0]  sw_bus
);

    logic       prev_rst_q = 1'b0;
    logic [1:0] since_q    = 2'd0;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (rst) begin
            since_q <= 2'd0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    logic [MSB_LINES-1:0] msb_now;
    logic [MID_LINES-1:0] mid_now;
    logic [MSB_LINES:0]   msb_ext;
    logic [MID_LINES:0]   mid_ext;
    logic                 msb_shape_ok;
    logic                 mid_shape_ok;
    int                   weight_now;

    always_comb begin
        msb_now      = sw_bus[MSB_BASE +: MSB_LINES];
        mid_now      = sw_bus[MID_BASE +: MID_LINES];
        msb_ext      = {1'b0, msb_now};
        mid_ext      = {1'b0, mid_now};
        msb_shape_ok = ((msb_ext + 1'b1) & msb_ext) == '0;
        mid_shape_ok = ((mid_ext + 1'b1) & mid_ext) == '0;
        weight_now   = MSB_WT * $countones(msb_now)
                     + MID_WT * $countones(mid_now)
                     + int'(sw_bus[LSB_W-1:0]);
    end

    // R1
    always @(posedge clk) begin
        if (prev_rst_q) begin
            rst_clear_chk: assert (sw_bus == '0)
                else $error("switch bus not cleared by reset");
        end
    end

    // R2
    latency_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && $past(valid_in, 2))
            |-> (weight_now == int'($past(code_in, 2))));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && !$past(valid_in, 2)) |-> $stable(sw_bus));

    // R4
    msb_shape_chk: assert property (@(posedge clk) disable iff (rst)
        msb_shape_ok);

    // R5
    mid_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mid_shape_ok);

    // R6
    fine_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && $past(valid_in, 2))
            |-> (sw_bus[LSB_W-1:0] == $past(code_in[LSB_W-1:0], 2)));

    // R8
    msb_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd1 && ($countones(msb_now) > $past($countones(msb_now))))
            |-> (($past(msb_now) & ~msb_now) == '0));

    // R8
    mid_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd1 && ($countones(mid_now) > $past($countones(mid_now))))
            |-> (($past(mid_now) & ~mid_now) == '0));

endmodule

bind segdac_switch_decoder segdac_switch_checker #(
    .MSB_W (MSB_W),
    .MID_W (MID_W),
    .LSB_W (LSB_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_in (valid_in),
    .code_in  (code_in),
    .sw_bus   (sw_bus)
);

// File: tb/segdac_switch_decoder_test.sv
module segdac_switch_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [13:0] code_in = '0;
    logic [50:0] sw_bus;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    segdac_switch_decoder uut (
        .clk      (clk),
        .rst      (rst),
        .valid_in (valid_in),
        .code_in  (code_in),
        .sw_bus   (sw_bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected bus from the requirements: R4 coarse at [50:20],
    // R5 middle at [19:5], R6 fine at [4:0].
    function automatic logic [50:0] expect_bus(input logic [13:0] c);
        logic [50:0] b;
        b = '0;
        for (int i = 0; i < 31; i++) b[20 + i] = (int'(c[13:9]) > i);
        for (int j = 0; j < 15; j++) b[5 + j]  = (int'(c[8:5]) > j);
        b[4:0] = c[4:0];
        return b;
    endfunction

    function automatic int bus_weight(input logic [50:0] b);
        int s;
        s = int'(b[4:0]);
        for (int i = 0; i < 31; i++) s += b[20 + i] ? 512 : 0;
        for (int j = 0; j < 15; j++) s += b[5 + j] ? 32 : 0;
        return s;
    endfunction

    // Behavioural model: loaded code and the code the output shows.
    logic [13:0] m_reg  = '0;
    logic [13:0] m_show = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_reg  <= '0;
            m_show <= '0;
        end else begin
            if (valid_in) m_reg <= code_in;
            m_show <= m_reg;
        end
    end

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    logic [50:0] prev_bus = '0;

    // Full comparison against the model plus the ordering check.
    task automatic cycle_check();
        logic [50:0] e;
        e = expect_bus(m_show);
        check("R4 coarse lines", 64'(sw_bus[50:20]), 64'(e[50:20]));
        check("R5 middle lines", 64'(sw_bus[19:5]),  64'(e[19:5]));
        check("R6 fine bits",    64'(sw_bus[4:0]),   64'(e[4:0]));
        check("R7 weighted sum", 64'(bus_weight(sw_bus)), 64'(m_show));
        if ($countones(sw_bus[50:20]) > $countones(prev_bus[50:20]))
            check("R8 coarse no drop", 64'(prev_bus[50:20] & ~sw_bus[50:20]), 64'd0);
        if ($countones(sw_bus[19:5]) > $countones(prev_bus[19:5]))
            check("R8 middle no drop", 64'(prev_bus[19:5] & ~sw_bus[19:5]), 64'd0);
        prev_bus = sw_bus;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_and_wait(input logic [13:0] c);
        valid_in = 1'b1;
        code_in  = c;
        step();
        valid_in = 1'b0;
        step();
        cycle_check();
    endtask

    initial begin
        logic [13:0] held;
        void'($urandom(32'd20240607));
        step(); step(); step();
        check("R1 reset clear", 64'(sw_bus), 64'd0);
        rst = 1'b0;
        step();
        check("R1 idle after reset", 64'(sw_bus), 64'd0);

        // R2: latency of exactly two edges.
        valid_in = 1'b1;
        code_in  = 14'h3FFF;
        step();
        valid_in = 1'b0;
        code_in  = 14'h0000;
        check("R2 not after one edge", 64'(sw_bus), 64'd0);
        step();
        check("R2 after two edges", 64'(sw_bus), 64'(expect_bus(14'h3FFF)));
        prev_bus = sw_bus;

        // Directed boundary codes across segment carries.
        load_and_wait(14'd0);
        load_and_wait(14'd31);
        load_and_wait(14'd32);
        load_and_wait(14'd511);
        load_and_wait(14'd512);
        load_and_wait(14'h1E0);
        load_and_wait(14'd16383);
        load_and_wait(14'd0);
        load_and_wait(14'd8191);
        load_and_wait(14'd8192);

        // R3: codes with the strobe low are ignored.
        held = 14'd5461;
        load_and_wait(held);
        for (int k = 0; k < 20; k++) begin
            code_in = 14'($urandom);
            step();
            check("R3 hold with strobe low", 64'(sw_bus), 64'(expect_bus(held)));
        end
        prev_bus = sw_bus;

        // R7: every code streamed once per cycle, ascending.
        valid_in = 1'b1;
        for (int c = 0; c < 16384; c++) begin
            code_in = 14'(c);
            step();
            cycle_check();
        end
        valid_in = 1'b0;
        step(); cycle_check();
        step(); cycle_check();

        // Random codes with a random strobe.
        for (int k = 0; k < 3000; k++) begin
            valid_in = 1'($urandom % 2);
            code_in  = 14'($urandom);
            step();
            cycle_check();
        end

        // R1: reset in the middle of traffic.
        valid_in = 1'b1;
        code_in  = 14'd12345;
        rst = 1'b1;
        step();
        check("R1 mid-run reset", 64'(sw_bus), 64'd0);
        rst = 1'b0;
        valid_in = 1'b0;
        step();
        check("R1 no stale code after reset", 64'(sw_bus), 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule